// File: doc/BRIEF.md
# Sensor Window Readout Sequencer

This block produces the pixel, line and frame timing that reads a rectangular window out of an image sensor array. By default the array is 1024 by 1024; the column and row widths are parameters. A host writes the two window corners, an idle gap that follows every line, and a row step through a small write port. With a row step above one, rows are skipped for interlaced or subsampled readout. The block walks the window row by row and presents the current column and row address together with pixel and line valid strobes. Each frame is opened by a one-cycle frame-start pulse.

Host writes land in a set of pending registers. The sequencer copies them into its working set only at the boundary between frames, so a frame never changes shape partway through. At that copy the pending window is tested. If one corner lies beyond the other on either axis, the pending window is discarded and the previous working window stays in use. The gap and step settings are copied regardless. A gap written below the variant's minimum is raised to that minimum, and a step of zero is taken as one.

Top module: `swr_seq`

## Requirements
- R1: While reset is asserted, pix_valid, line_valid and frame_start are low and col and row are 0. After release, the first frame covers the full array (corners 0,0 and all-ones,all-ones), with an 8-cycle gap after each line and a row step of 1.
- R2: Within a line, col counts up by one per cycle from x0 to x1 inclusive. pix_valid and line_valid are both high on every one of those cycles, and row holds constant. Outside pixel cycles, both strobes are low.
- R3: Between two lines of the same frame, pix_valid stays low for exactly the active gap value in cycles.
- R4: After each line the row advances by the active step. When the advanced row would exceed y1, the frame ends. The last line's gap is followed by one frame-start cycle, and the next frame begins at row y0. The low time across a frame boundary is therefore the old gap plus one.
- R5: frame_start is high for exactly one cycle per frame, and pix_valid and line_valid are low in that cycle.
- R6: Corner, gap and step writes do not change the frame in progress. They take effect from the next frame start.
- R7: At a frame start, a pending window with x0 > x1 or y0 > y1 is ignored and the previous window is kept. Pending gap and step values still take effect.
- R8: A gap value written below PAUSE_MIN (5 or 8, default 5) is used as PAUSE_MIN.
- R9: A step value of 0 is used as 1.
- R10: Write map on wr_addr: 0 = x0, 1 = x1, 2 = y0, 3 = y1, 4 = gap, 5 = step. Values sit in the low bits of wr_data. Writes to addresses 6 and 7 change nothing.
- R11: Gap values up to 255 are accepted unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | DATA_W | Host write value, LSB aligned |
| pix_valid | output | 1 | Current cycle carries a window pixel |
| line_valid | output | 1 | A line's pixel run is in progress |
| frame_start | output | 1 | One-cycle pulse opening each frame |
| col | output | COL_W | Current column address |
| row | output | ROW_W | Current row address |

## Verification
The sequencer first runs the full reset frame. It then runs a narrow mid-array window written partway through a frame, which separates shadowed loading from immediate loading. A single-column window with a step of three and the widest gap follows; it shows whether rows are skipped and whether the end-of-frame test uses the stepped row. Next comes an inverted-column write combined with a short gap and a zero step, which distinguishes rejecting only the window from rejecting the whole write set, and also exercises gap clamping and the zero-step case. The last patterns are a window that ends on the top row, where the next stepped row no longer fits the row width, and an inverted-row write mixed with writes to unused addresses.

// File: rtl/swr_pkg.sv
package swr_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FS   = 2'd1,
      ST_ACT  = 2'd2,
      ST_GAP  = 2'd3
   } swr_state_e;

   localparam int SWR_ADDR_W = 3;

   localparam logic [SWR_ADDR_W-1:0] A_X0    = 3'd0;
   localparam logic [SWR_ADDR_W-1:0] A_X1    = 3'd1;
   localparam logic [SWR_ADDR_W-1:0] A_Y0    = 3'd2;
   localparam logic [SWR_ADDR_W-1:0] A_Y1    = 3'd3;
   localparam logic [SWR_ADDR_W-1:0] A_GAP   = 3'd4;
   localparam logic [SWR_ADDR_W-1:0] A_STEP  = 3'd5;

endpackage

// File: rtl/swr_cfg_regs.sv
module swr_cfg_regs
   import swr_pkg::*;
#(
   parameter int COL_W     = 10,
   parameter int ROW_W     = 10,
   parameter int PAUSE_W   = 8,
   parameter int DATA_W    = 16,
   parameter int PAUSE_MIN = 5,
   parameter int PAUSE_RST = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [SWR_ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic                  apply,
   output logic [COL_W-1:0]      act_x0,
   output logic [COL_W-1:0]      act_x1,
   output logic [ROW_W-1:0]      act_y0,
   output logic [ROW_W-1:0]      act_y1,
   output logic [PAUSE_W-1:0]    act_gap,
   output logic [ROW_W-1:0]      act_step
);

   localparam logic [COL_W-1:0]   COL_MAX  = {COL_W{1'b1}};
   localparam logic [ROW_W-1:0]   ROW_MAX  = {ROW_W{1'b1}};
   localparam logic [PAUSE_W-1:0] GAP_RST  = PAUSE_W'(PAUSE_RST);
   localparam logic [PAUSE_W-1:0] GAP_MIN  = PAUSE_W'(PAUSE_MIN);
   localparam logic [ROW_W-1:0]   STEP_ONE = ROW_W'(1);

   logic [COL_W-1:0]   pend_x0, pend_x1;
   logic [ROW_W-1:0]   pend_y0, pend_y1;
   logic [PAUSE_W-1:0] pend_gap;
   logic [ROW_W-1:0]   pend_step;

   logic [PAUSE_W-1:0] gap_raw, gap_fix;
   logic [ROW_W-1:0]   step_raw, step_fix;
   logic               win_ok;

   assign gap_raw  = wr_data[PAUSE_W-1:0];
   assign step_raw = wr_data[ROW_W-1:0];

   // gap floor: variant picked by the minimum parameter
   generate
      if (PAUSE_MIN > 1) begin : g_gap_floor
         assign gap_fix = (gap_raw < GAP_MIN) ? GAP_MIN : gap_raw;
      end else begin : g_gap_plain
         assign gap_fix = (gap_raw == '0) ? PAUSE_W'(1) : gap_raw;
      end
   endgenerate

   assign step_fix = (step_raw == '0) ? STEP_ONE : step_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_x0   <= '0;
         pend_x1   <= COL_MAX;
         pend_y0   <= '0;
         pend_y1   <= ROW_MAX;
         pend_gap  <= GAP_RST;
         pend_step <= STEP_ONE;
      end else if (wr_en) begin
         case (wr_addr)
            A_X0:    pend_x0   <= wr_data[COL_W-1:0];
            A_X1:    pend_x1   <= wr_data[COL_W-1:0];
            A_Y0:    pend_y0   <= wr_data[ROW_W-1:0];
            A_Y1:    pend_y1   <= wr_data[ROW_W-1:0];
            A_GAP:   pend_gap  <= gap_fix;
            A_STEP:  pend_step <= step_fix;
            default: ;
         endcase
      end
   end

   assign win_ok = (pend_x0 <= pend_x1) && (pend_y0 <= pend_y1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_x0   <= '0;
         act_x1   <= COL_MAX;
         act_y0   <= '0;
         act_y1   <= ROW_MAX;
         act_gap  <= GAP_RST;
         act_step <= STEP_ONE;
      end else if (apply) begin
         act_gap  <= pend_gap;
         act_step <= pend_step;
         if (win_ok) begin
            act_x0 <= pend_x0;
            act_x1 <= pend_x1;
            act_y0 <= pend_y0;
            act_y1 <= pend_y1;
         end
      end
   end

endmodule

// File: rtl/swr_row_step.sv
module swr_row_step #(
   parameter int ROW_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ROW_W-1:0] y0,
   input  logic [ROW_W-1:0] y1,
   input  logic [ROW_W-1:0] step,
   input  logic             load,
   input  logic             advance,
   output logic [ROW_W-1:0] row,
   output logic             row_last
);

   localparam int SUM_W = ROW_W + 1;

   logic [SUM_W-1:0] row_next;

   // one spare bit so a step past the top row is seen, not wrapped
   assign row_next = {1'b0, row} + {1'b0, step};
   assign row_last = row_next > {1'b0, y1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row <= '0;
      end else if (load) begin
         row <= y0;
      end else if (advance) begin
         row <= row_next[ROW_W-1:0];
      end
   end

endmodule

// File: rtl/swr_line_timer.sv
module swr_line_timer
   import swr_pkg::*;
#(
   parameter int COL_W   = 10,
   parameter int PAUSE_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [COL_W-1:0]   x0,
   input  logic [COL_W-1:0]   x1,
   input  logic [PAUSE_W-1:0] gap,
   input  logic               row_last,
   output logic               apply,
   output logic               load_row,
   output logic               advance,
   output logic               pix_valid,
   output logic               line_valid,
   output logic               frame_start,
   output logic [COL_W-1:0]   col
);

   localparam logic [PAUSE_W-1:0] CNT_ONE = PAUSE_W'(1);

   swr_state_e         state_q, state_d;
   logic [PAUSE_W-1:0] cnt_q;
   logic               line_done, gap_done;

   assign line_done = (state_q == ST_ACT) && (col == x1);
   assign gap_done  = (state_q == ST_GAP) && (cnt_q == '0);

   always_comb begin
      state_d  = state_q;
      apply    = 1'b0;
      load_row = 1'b0;
      advance  = 1'b0;
      case (state_q)
         ST_IDLE: begin
            state_d = ST_FS;
            apply   = 1'b1;
         end
         ST_FS: begin
            state_d  = ST_ACT;
            load_row = 1'b1;
         end
         ST_ACT: begin
            if (line_done) state_d = ST_GAP;
         end
         ST_GAP: begin
            if (gap_done) begin
               if (row_last) begin
                  state_d = ST_FS;
                  apply   = 1'b1;
               end else begin
                  state_d = ST_ACT;
                  advance = 1'b1;
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         col     <= '0;
      end else begin
         state_q <= state_d;
         if (line_done) begin
            cnt_q <= gap - CNT_ONE;
         end else if (state_q == ST_GAP && cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_ONE;
         end
         if (load_row || advance) begin
            col <= x0;
         end else if (state_q == ST_ACT && !line_done) begin
            col <= col + COL_W'(1);
         end
      end
   end

   assign pix_valid   = (state_q == ST_ACT);
   assign line_valid  = (state_q == ST_ACT);
   assign frame_start = (state_q == ST_FS);

endmodule

// File: rtl/swr_seq.sv
module swr_seq
   import swr_pkg::*;
#(
   parameter int COL_W     = 10,
   parameter int ROW_W     = 10,
   parameter int PAUSE_W   = 8,
   parameter int PAUSE_MIN = 5,
   parameter int PAUSE_RST = 8,
   parameter int ADDR_W    = SWR_ADDR_W,
   parameter int DATA_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              pix_valid,
   output logic              line_valid,
   output logic              frame_start,
   output logic [COL_W-1:0]  col,
   output logic [ROW_W-1:0]  row
);

   localparam int WIDEST = (COL_W > ROW_W) ? ((COL_W > PAUSE_W) ? COL_W : PAUSE_W)
                                           : ((ROW_W > PAUSE_W) ? ROW_W : PAUSE_W);
   localparam int GAP_TOP = (1 << PAUSE_W) - 1;

   generate
      if (PAUSE_MIN != 5 && PAUSE_MIN != 8) begin : g_bad_min
         $error("swr_seq: PAUSE_MIN must be 5 or 8");
      end
      if (PAUSE_RST < PAUSE_MIN || PAUSE_RST > GAP_TOP) begin : g_bad_rst
         $error("swr_seq: PAUSE_RST outside the legal gap range");
      end
      if (DATA_W < WIDEST) begin : g_bad_data
         $error("swr_seq: DATA_W narrower than a register field");
      end
      if (ADDR_W != SWR_ADDR_W) begin : g_bad_addr
         $error("swr_seq: ADDR_W must match the register map width");
      end
   endgenerate

   logic [COL_W-1:0]   act_x0, act_x1;
   logic [ROW_W-1:0]   act_y0, act_y1, act_step;
   logic [PAUSE_W-1:0] act_gap;
   logic               apply, load_row, advance, row_last;

   swr_cfg_regs #(
      .COL_W     (COL_W),
      .ROW_W     (ROW_W),
      .PAUSE_W   (PAUSE_W),
      .DATA_W    (DATA_W),
      .PAUSE_MIN (PAUSE_MIN),
      .PAUSE_RST (PAUSE_RST)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .apply    (apply),
      .act_x0   (act_x0),
      .act_x1   (act_x1),
      .act_y0   (act_y0),
      .act_y1   (act_y1),
      .act_gap  (act_gap),
      .act_step (act_step)
   );

   swr_line_timer #(
      .COL_W   (COL_W),
      .PAUSE_W (PAUSE_W)
   ) u_line (
      .clk         (clk),
      .rst_n       (rst_n),
      .x0          (act_x0),
      .x1          (act_x1),
      .gap         (act_gap),
      .row_last    (row_last),
      .apply       (apply),
      .load_row    (load_row),
      .advance     (advance),
      .pix_valid   (pix_valid),
      .line_valid  (line_valid),
      .frame_start (frame_start),
      .col         (col)
   );

   swr_row_step #(
      .ROW_W (ROW_W)
   ) u_row (
      .clk      (clk),
      .rst_n    (rst_n),
      .y0       (act_y0),
      .y1       (act_y1),
      .step     (act_step),
      .load     (load_row),
      .advance  (advance),
      .row      (row),
      .row_last (row_last)
   );

endmodule

// File: rtl/swr_seq_chk.sv
module swr_seq_chk #(
   parameter int COL_W     = 10,
   parameter int ROW_W     = 10,
   parameter int PAUSE_MIN = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pix_valid,
   input logic             line_valid,
   input logic             frame_start,
   input logic [COL_W-1:0] col,
   input logic [ROW_W-1:0] row
);

   localparam int GAP_W = 10;

   logic [GAP_W-1:0] low_cnt;
   logic             seen_pix;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt  <= '0;
         seen_pix <= 1'b0;
      end else begin
         if (pix_valid) begin
            low_cnt  <= '0;
            seen_pix <= 1'b1;
         end else if (low_cnt != {GAP_W{1'b1}}) begin
            low_cnt <= low_cnt + GAP_W'(1);
         end
      end
   end

   assert_col_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && $past(pix_valid)) |-> (col == $past(col) + COL_W'(1)) && (row == $past(row)));

   assert_gap_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pix_valid) && seen_pix) |-> (low_cnt >= GAP_W'(PAUSE_MIN)));

   assert_row_rises_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pix_valid) && !$past(frame_start)) |-> (row > $past(row)));

   assert_fs_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !frame_start);

   assert_fs_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> (!pix_valid && !line_valid));

endmodule

bind swr_seq swr_seq_chk #(
   .COL_W     (COL_W),
   .ROW_W     (ROW_W),
   .PAUSE_MIN (PAUSE_MIN)
) u_swr_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pix_valid   (pix_valid),
   .line_valid  (line_valid),
   .frame_start (frame_start),
   .col         (col),
   .row         (row)
);

// File: tb/swr_seq_bench.sv
module swr_seq_bench;

   localparam int CW  = 6;
   localparam int RW  = 6;
   localparam int PMN = 5;
   localparam int AW  = 3;
   localparam int DW  = 16;
   localparam int TOP = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          pix_valid, line_valid, frame_start;
   logic [CW-1:0] col;
   logic [RW-1:0] row;

   int checks = 0;
   int errors = 0;

   // pending and active register model
   int p_x0 = 0, p_x1 = TOP, p_y0 = 0, p_y1 = TOP, p_gap = 8, p_step = 1;
   int a_x0 = 0, a_x1 = TOP, a_y0 = 0, a_y1 = TOP, a_gap = 8, a_step = 1;
   bit first_frame = 1'b1;
   bit run_mon = 1'b0;
   int low_cnt = 0;

   int q_col[$];
   int q_row[$];
   int q_gap[$];

   always #2.5 clk = ~clk;

   swr_seq #(
      .COL_W     (CW),
      .ROW_W     (RW),
      .PAUSE_W   (8),
      .PAUSE_MIN (PMN),
      .PAUSE_RST (8),
      .ADDR_W    (AW),
      .DATA_W    (DW)
   ) u_swr_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .pix_valid   (pix_valid),
      .line_valid  (line_valid),
      .frame_start (frame_start),
      .col         (col),
      .row         (row)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // driver: one host write, mirrored into the pending model (R8 R9 R10)
   task automatic host_wr(input int addr, input int data);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = AW'(addr);
      wr_data = DW'(data);
      @(negedge clk);
      wr_en = 1'b0;
      case (addr)
         0: p_x0 = data & TOP;
         1: p_x1 = data & TOP;
         2: p_y0 = data & TOP;
         3: p_y1 = data & TOP;
         4: p_gap = ((data & 255) < PMN) ? PMN : (data & 255);
         5: p_step = ((data & TOP) == 0) ? 1 : (data & TOP);
         default: ;
      endcase
   endtask

   task automatic wait_fs();
      @(negedge clk);
      while (!frame_start) @(negedge clk);
      @(negedge clk);
      @(negedge clk);
   endtask

   // scoreboard fill at each frame start: shadow load and window test
   task automatic load_frame();
      int old_gap;
      old_gap = a_gap;
      a_gap   = p_gap;
      a_step  = p_step;
      if (p_x0 <= p_x1 && p_y0 <= p_y1) begin
         a_x0 = p_x0; a_x1 = p_x1; a_y0 = p_y0; a_y1 = p_y1;
      end
      for (int y = a_y0; y <= a_y1; y += a_step) begin
         for (int x = a_x0; x <= a_x1; x++) begin
            q_col.push_back(x);
            q_row.push_back(y);
            if (x != a_x0)        q_gap.push_back(0);
            else if (y != a_y0)   q_gap.push_back(a_gap);
            else if (first_frame) q_gap.push_back(-1);
            else                  q_gap.push_back(old_gap + 1);
         end
      end
      first_frame = 1'b0;
   endtask

   // monitor
   always @(negedge clk) begin
      if (run_mon) begin
         if (frame_start) begin
            check(q_col.size() == 0, "R4 frame length (pixels left)", q_col.size(), 0);
            check(!pix_valid && !line_valid, "R5 strobes low at frame start", pix_valid, 0);
            load_frame();
            low_cnt++;
         end else if (pix_valid) begin
            if (q_col.size() == 0) begin
               check(1'b0, "R6 unexpected pixel", int'(col), -1);
            end else begin
               int ec, er, eg;
               ec = q_col.pop_front();
               er = q_row.pop_front();
               eg = q_gap.pop_front();
               check(int'(col) == ec, "R2 column", int'(col), ec);
               check(int'(row) == er, "R4 row", int'(row), er);
               check(line_valid == 1'b1, "R2 line_valid with pixel", line_valid, 1);
               if (eg > 0)
                  check(low_cnt == eg, "R3 gap length", low_cnt, eg);
            end
            low_cnt = 0;
         end else begin
            check(line_valid == 1'b0, "R2 line_valid outside pixels", line_valid, 0);
            low_cnt++;
         end
      end
   end

   initial begin
      #(200000 * 5);
      check(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(pix_valid == 0,   "R1 reset pix_valid",   pix_valid, 0);
      check(line_valid == 0,  "R1 reset line_valid",  line_valid, 0);
      check(frame_start == 0, "R1 reset frame_start", frame_start, 0);
      check(col == 0,         "R1 reset col",         int'(col), 0);
      check(row == 0,         "R1 reset row",         int'(row), 0);
      run_mon = 1'b1;
      rst_n   = 1'b1;

      // R1 default full frame; R6 writes made during it apply one frame later
      wait_fs();
      host_wr(0, 2); host_wr(1, 9); host_wr(2, 3); host_wr(3, 20);
      host_wr(4, 6); host_wr(5, 1);

      // R11 widest gap, row skipping with step 3, single column
      wait_fs();
      host_wr(0, 5); host_wr(1, 5); host_wr(2, 0); host_wr(3, 10);
      host_wr(4, 255); host_wr(5, 3);

      // R7 inverted columns, R8 gap clamp, R9 step of zero
      wait_fs();
      host_wr(0, 10); host_wr(1, 4); host_wr(4, 2); host_wr(5, 0);

      // R4 window ending on the top row, next stepped row out of range
      wait_fs();
      host_wr(1, 12); host_wr(2, 60); host_wr(3, 63); host_wr(5, 2);

      // R7 inverted rows, R10 unused addresses, upper data bits ignored
      wait_fs();
      host_wr(2, 40); host_wr(3, 30); host_wr(6, 0); host_wr(7, 1);
      host_wr(4, 32'h0000_0114);

      wait_fs();
      wait_fs();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule